// File: doc/BRIEF.md
# Packed Palette Color Lookup

The block holds a 256-color lookup table in a RAM of 128 words of 32 bits, with two 16-bit color entries in each word. A register-style bus port writes and reads whole words by word address. A pixel port takes an 8-bit color index and returns a 24-bit RGB value one clock later, together with a registered valid flag.

Each 16-bit entry carries three 5-bit components and one intensity bit. The intensity bit does not reach the output. Each component is widened to 8 bits by placing it in the top five bits, with the low three bits cleared. A swap input exchanges the red and blue output channels. The swap is applied when the looked-up color is registered.

Top module: `pal_lut`

## Requirements
- R1: After reset, `pix_vld_o` is 0 and `pix_rgb_o` is 0.
- R2: `pix_vld_o` equals the `pix_req_i` of the previous clock. `pix_rgb_o` changes only in a cycle that follows a request.
- R3: A bus write with `bus_we_i` high stores `bus_wdata_i` into word `bus_addr_i`. The read port `bus_rdata_o` returns the word at `bus_addr_i` one clock after the address is presented.
- R4: An even index 2k selects bits [15:0] of word k. An odd index 2k+1 selects bits [31:16] of word k.
- R5: Within an entry, red is bits [4:0], green is bits [9:5] and blue is bits [14:10].
- R6: Bit 15 of an entry has no effect on `pix_rgb_o`.
- R7: Each component c appears on the output as {c, 3'b000}. The output is packed as R in [23:16], G in [15:8] and B in [7:0].
- R8: When `swap_rb_i` is high during the request cycle, the red and blue output bytes are exchanged.
- R9: When a bus write and a pixel request address the same word in the same cycle, the write is stored. The pixel result returns the data held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_we_i | input | 1 | Word write enable |
| bus_addr_i | input | 7 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| pix_req_i | input | 1 | Pixel lookup request |
| pix_idx_i | input | 8 | Color index |
| swap_rb_i | input | 1 | Exchange the red and blue outputs |
| pix_vld_o | output | 1 | Lookup result valid |
| pix_rgb_o | output | 24 | Expanded color |

## Verification
The bench targets the following corner cases:
- **Half selection.** It writes different entries into the two halves of each word. A design that reverses the half selection returns the neighbouring entry's color.
- **Intensity bit.** It sets bit 15 on chosen entries. A design that leaks bit 15 into a channel shows a stray bit in blue or red.
- **Expansion and swap.** It checks the full-scale values 5'h1f and 5'h01 with the swap input both high and low. This catches replicated low bits, a shift by the wrong amount and a reversed swap.
- **Same-word collision.** It writes and requests the same word in one cycle. A design that forwards the new write returns the new color where the old one is expected.

// File: rtl/pal_lut.sv
module pal_lut #(
  parameter int IDX_W = 8,
  parameter int CW    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [IDX_W-2:0]  bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              pix_req_i,
  input  logic [IDX_W-1:0]  pix_idx_i,
  input  logic              swap_rb_i,
  output logic              pix_vld_o,
  output logic [3*8-1:0]    pix_rgb_o
);
  localparam int WORDS = 1 << (IDX_W - 1);
  localparam int PAD   = 8 - CW;

  logic [31:0] mem [WORDS];
  logic [31:0] pix_word;
  logic [15:0] ent;
  logic [7:0]  r8, g8, b8;

  assign pix_word = mem[pix_idx_i[IDX_W-1:1]];
  assign ent = pix_idx_i[0] ? pix_word[31:16] : pix_word[15:0];
  assign r8  = {ent[CW-1:0],      {PAD{1'b0}}};
  assign g8  = {ent[2*CW-1:CW],   {PAD{1'b0}}};
  assign b8  = {ent[3*CW-1:2*CW], {PAD{1'b0}}};

  always_ff @(posedge clk_i) begin
    if (bus_we_i) mem[bus_addr_i] <= bus_wdata_i;
    bus_rdata_o <= mem[bus_addr_i];
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pix_vld_o <= 1'b0;
      pix_rgb_o <= '0;
    end else begin
      pix_vld_o <= pix_req_i;
      if (pix_req_i)
        pix_rgb_o <= swap_rb_i ? {b8, g8, r8} : {r8, g8, b8};
    end
  end
endmodule

// File: rtl/pal_lut_chk.sv
module pal_lut_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        pix_req_i,
  input logic        pix_vld_o,
  input logic [23:0] pix_rgb_o
);
  // R2
  vld_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_req_i |=> pix_vld_o);
  // R2
  vld_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_req_i |=> !pix_vld_o);
  // R2
  rgb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pix_req_i && !$past(!rst_ni)) |=> $stable(pix_rgb_o));
  // R7
  low_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_vld_o |-> (pix_rgb_o[2:0] == 3'b0 && pix_rgb_o[10:8] == 3'b0 && pix_rgb_o[18:16] == 3'b0));
endmodule

bind pal_lut pal_lut_chk u_chk (.*);

// File: tb/test_pal_lut.sv
module test_pal_lut;
  logic clk = 0, rst_n = 0;
  logic we = 0, req = 0, swp = 0;
  logic [6:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [7:0] idx = 0;
  logic vld;
  logic [23:0] rgb;
  logic [31:0] model [128];
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  pal_lut i_pal_lut (.clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pix_req_i(req), .pix_idx_i(idx),
    .swap_rb_i(swp), .pix_vld_o(vld), .pix_rgb_o(rgb));

  function automatic logic [23:0] exp_rgb(logic [31:0] w, logic odd, logic s);
    logic [15:0] e = odd ? w[31:16] : w[15:0];
    logic [7:0] r = {e[4:0], 3'b0}, g = {e[9:5], 3'b0}, b = {e[14:10], 3'b0};
    return s ? {b, g, r} : {r, g, b};
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d; model[a] = d;
    @(negedge clk); we = 0;
  endtask

  task automatic look(logic [7:0] i, logic s, string rq);
    @(negedge clk); req = 1; idx = i; swp = s;
    @(negedge clk); req = 0;
    chk({rq, " vld"}, {31'b0, vld}, 1);
    chk(rq, {8'b0, rgb}, {8'b0, exp_rgb(model[i[7:1]], i[0], s)});
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk("R1 vld", {31'b0, vld}, 0);
    chk("R1 rgb", {8'b0, rgb}, 0);
    rst_n = 1;
    for (int k = 0; k < 128; k++) wr(k[6:0], $urandom);
    // R3 readback
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); addr = 7'(k * 13);
      @(negedge clk); chk("R3", rdata, model[7'(k * 13)]);
    end
    // R4 R5 R7 directed: low half red full, upper half blue 1
    wr(7'd5, {1'b0, 5'h01, 5'h00, 5'h00, 1'b0, 5'h00, 5'h00, 5'h1f});
    look(8'd10, 0, "R4 R5 R7 even");
    chk("R5", {8'b0, rgb}, 32'h00F80000);
    look(8'd11, 0, "R4 odd");
    chk("R7", {8'b0, rgb}, 32'h00000008);
    look(8'd11, 1, "R8 swap");
    chk("R8", {8'b0, rgb}, 32'h00080000);
    // R6 intensity bit
    wr(7'd6, 32'h8000_8000);
    look(8'd12, 0, "R6");
    chk("R6 zero", {8'b0, rgb}, 0);
    look(8'd13, 1, "R6 odd");
    // R2 hold when no request
    @(negedge clk); idx = 8'd20;
    @(negedge clk);
    chk("R2 vld low", {31'b0, vld}, 0);
    chk("R2 hold", {8'b0, rgb}, {8'b0, exp_rgb(model[6], 1'b1, 1'b1)});
    // R9 collision
    wr(7'd40, 32'h7fff_1234);
    @(negedge clk); we = 1; addr = 7'd40; wdata = 32'h0000_0000;
    req = 1; idx = 8'd81; swp = 0;
    @(negedge clk); we = 0; req = 0;
    chk("R9 old", {8'b0, rgb}, {8'b0, exp_rgb(32'h7fff_1234, 1'b1, 1'b0)});
    model[40] = 0;
    look(8'd81, 0, "R9 new");
    // random
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 2) == 0) wr(7'($urandom), $urandom);
      else look(8'($urandom), 1'($urandom), "R4 R5 R7 R8 rand");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule